// File: doc/BRIEF.md
# Two-Port Synchronous Static RAM

This block is a word-organised static RAM with two equal access ports, A and B. In any cycle either port can read or write any word, and both ports can target the same word. Each port registers its control, address and write data on the clock edge. It applies the registered command on the following edge. Read data then leaves through an output register, so a read has one cycle of pipeline latency.

Each port has two select inputs of opposite polarity. The port is active only when the active-low select is low and the active-high select is high. Any other combination, sampled on one edge, powers the port down. The port's drive enable drops and its read data is forced to zero, and a write arriving in that state is dropped. A port recovering from power-down drives again only after one fully selected cycle has passed through the pipeline. When both ports write one word in the same cycle, a collision flag is raised. Port A's data is the value kept.

Both ports share one clock. The drive-enable outputs are intended to control the pad tri-state buffers.

Top module: `twin_port_ram`

## Requirements
- R1: A read whose command is sampled on edge k presents the stored word on that port's read data after edge k+1, with the drive enable high.
- R2: The two ports work independently. A write on A and a write on B to different words in the same cycle both land, and a later read on either port returns each word.
- R3: When both ports read the same word in the same cycle, both return the same stored value.
- R4: When port A writes a word and port B reads that word in the same cycle, B returns the old contents. A read by B in a later cycle returns the new value.
- R5: When both ports write the same word in the same cycle, the collision output is high for exactly one cycle, after edge k+1. The word then holds port A's data.
- R6: A write uses only the values sampled on its edge. Changes to the write enable or write data after that edge do not affect the stored word.
- R7: A port is powered down when, at an edge, its active-low select is high or its active-high select is low. From that edge on, its drive enable is low and its read data reads zero, and a write command sampled while it is powered down leaves the memory unchanged.
- R8: After power-down, a read sampled on the first fully selected edge k does not drive at edge k. It drives at edge k+1.
- R9: A write sampled on edge k leaves that port's drive enable low after edge k+1.
- R10: While reset (active-low) is asserted, both drive enables, both read data buses and the collision output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Asynchronous active-low reset |
| selNA | input | 1 | Port A select, active low |
| selA | input | 1 | Port A select, active high |
| wrEnA | input | 1 | Port A command: 1 write, 0 read |
| addrA | input | ADDR_W | Port A word address |
| wdataA | input | DATA_W | Port A write data |
| rdataA | output | DATA_W | Port A read data, zero when not driving |
| drvA | output | 1 | Port A output drive enable |
| selNB | input | 1 | Port B select, active low |
| selB | input | 1 | Port B select, active high |
| wrEnB | input | 1 | Port B command: 1 write, 0 read |
| addrB | input | ADDR_W | Port B word address |
| wdataB | input | DATA_W | Port B write data |
| rdataB | output | DATA_W | Port B read data, zero when not driving |
| drvB | output | 1 | Port B output drive enable |
| clash | output | 1 | Same-word dual write seen one cycle earlier |

## Verification
Read data and the collision flag are due one edge after the command's sampling edge. The bench sets inputs at a falling edge and moves forward two falling edges before it samples a read or collision result. Power-down takes effect on the sampling edge itself, so the bench checks it after a single falling edge. Wake-up is checked at both edges: the port must still be quiet after the first fully selected edge and must drive after the next one. A memory write lands one edge after sampling, so a same-port read issued right after the write already sees the new value. A cross-port read in the write's own cycle sees the old value, and the bench expects each of these results at that exact offset.

// File: rtl/twin_port_ram_pkg.sv
package twin_port_ram_pkg;
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic rdA;
    logic rdB;
  } ram_strobe_t;
endpackage

// File: rtl/ram_port_capture.sv
module ram_port_capture #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              liveEn,
  output logic              cmdEn,
  output logic              cmdWr,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);
  // Port is live only with both selects in their active state.
  assign liveEn = !selN && sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdEn   <= 1'b0;
      cmdWr   <= 1'b0;
      cmdAddr <= '0;
      cmdData <= '0;
    end else begin
      cmdEn   <= liveEn;
      cmdWr   <= wrEn;
      cmdAddr <= addr;
      cmdData <= wdata;
    end
  end
endmodule

// File: rtl/ram_ctrl.sv
module ram_ctrl
  import twin_port_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              liveEnA,
  input  logic              cmdEnA,
  input  logic              cmdWrA,
  input  logic [ADDR_W-1:0] cmdAddrA,
  input  logic              liveEnB,
  input  logic              cmdEnB,
  input  logic              cmdWrB,
  input  logic [ADDR_W-1:0] cmdAddrB,
  output ram_strobe_t       stb,
  output logic              drvA,
  output logic              drvB,
  output logic              clash
);
  logic sameWord;

  always_comb begin
    stb.wrA  = cmdEnA && cmdWrA;
    stb.rdA  = cmdEnA && !cmdWrA;
    stb.wrB  = cmdEnB && cmdWrB;
    stb.rdB  = cmdEnB && !cmdWrB;
    sameWord = (cmdAddrA == cmdAddrB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvA  <= 1'b0;
      drvB  <= 1'b0;
      clash <= 1'b0;
    end else begin
      // Drive only when the port is live now and the sampled command was a read.
      drvA  <= liveEnA && stb.rdA;
      drvB  <= liveEnB && stb.rdB;
      clash <= stb.wrA && stb.wrB && sameWord;
    end
  end
endmodule

// File: rtl/ram_datapath.sv
module ram_datapath
  import twin_port_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  ram_strobe_t       stb,
  input  logic [ADDR_W-1:0] cmdAddrA,
  input  logic [DATA_W-1:0] cmdDataA,
  input  logic [ADDR_W-1:0] cmdAddrB,
  input  logic [DATA_W-1:0] cmdDataB,
  input  logic              drvA,
  input  logic              drvB,
  output logic [DATA_W-1:0] rdataA,
  output logic [DATA_W-1:0] rdataB
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdReg [2];
  logic [ADDR_W-1:0] rdAddr [2];
  logic              rdStb [2];
  logic              drv [2];
  logic [DATA_W-1:0] rdOut [2];

  assign rdAddr[0] = cmdAddrA;
  assign rdAddr[1] = cmdAddrB;
  assign rdStb[0]  = stb.rdA;
  assign rdStb[1]  = stb.rdB;
  assign drv[0]    = drvA;
  assign drv[1]    = drvB;

  // B first, then A: on a same-word collision A's data is kept.
  always_ff @(posedge clk) begin
    if (stb.wrB) mem[cmdAddrB] <= cmdDataB;
    if (stb.wrA) mem[cmdAddrA] <= cmdDataA;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rdStb[p]) rdReg[p] <= mem[rdAddr[p]];
    end
    assign rdOut[p] = drv[p] ? rdReg[p] : '0;
  end

  assign rdataA = rdOut[0];
  assign rdataB = rdOut[1];
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_port_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selNA,
  input  logic              selA,
  input  logic              wrEnA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] wdataA,
  output logic [DATA_W-1:0] rdataA,
  output logic              drvA,
  input  logic              selNB,
  input  logic              selB,
  input  logic              wrEnB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] wdataB,
  output logic [DATA_W-1:0] rdataB,
  output logic              drvB,
  output logic              clash
);
  logic              liveEnA, cmdEnA, cmdWrA;
  logic              liveEnB, cmdEnB, cmdWrB;
  logic [ADDR_W-1:0] cmdAddrA, cmdAddrB;
  logic [DATA_W-1:0] cmdDataA, cmdDataB;
  ram_strobe_t       stb;

  ram_port_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) capA_i (
    .clk(clk), .rstN(rstN), .selN(selNA), .sel(selA), .wrEn(wrEnA),
    .addr(addrA), .wdata(wdataA), .liveEn(liveEnA), .cmdEn(cmdEnA),
    .cmdWr(cmdWrA), .cmdAddr(cmdAddrA), .cmdData(cmdDataA));

  ram_port_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) capB_i (
    .clk(clk), .rstN(rstN), .selN(selNB), .sel(selB), .wrEn(wrEnB),
    .addr(addrB), .wdata(wdataB), .liveEn(liveEnB), .cmdEn(cmdEnB),
    .cmdWr(cmdWrB), .cmdAddr(cmdAddrB), .cmdData(cmdDataB));

  ram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .liveEnA(liveEnA), .cmdEnA(cmdEnA), .cmdWrA(cmdWrA), .cmdAddrA(cmdAddrA),
    .liveEnB(liveEnB), .cmdEnB(cmdEnB), .cmdWrB(cmdWrB), .cmdAddrB(cmdAddrB),
    .stb(stb), .drvA(drvA), .drvB(drvB), .clash(clash));

  ram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .stb(stb),
    .cmdAddrA(cmdAddrA), .cmdDataA(cmdDataA),
    .cmdAddrB(cmdAddrB), .cmdDataB(cmdDataB),
    .drvA(drvA), .drvB(drvB), .rdataA(rdataA), .rdataB(rdataB));
endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              selNA,
  input logic              selA,
  input logic              wrEnA,
  input logic [ADDR_W-1:0] addrA,
  input logic [DATA_W-1:0] rdataA,
  input logic              drvA,
  input logic              selNB,
  input logic              selB,
  input logic              wrEnB,
  input logic [ADDR_W-1:0] addrB,
  input logic [DATA_W-1:0] rdataB,
  input logic              drvB,
  input logic              clash
);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (!drvA && !drvB && !clash && rdataA == '0 && rdataB == '0));

  assert_powerdown_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    (selNA || !selA) |=> !drvA);

  assert_powerdown_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    (selNB || !selB) |=> !drvB);

  assert_undriven_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!drvA |-> rdataA == '0) and (!drvB |-> rdataB == '0));

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!selNA && selA && !wrEnA) ##1 (!selNA && selA) |=> drvA);

  assert_wake_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    (selNB || !selB) ##1 (!selNB && selB) |=> !drvB);

  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!selNA && selA && wrEnA) |=> ##1 !drvA);

  assert_collision_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!selNA && selA && wrEnA && !selNB && selB && wrEnB && addrA == addrB)
      |=> ##1 clash);
endmodule

bind twin_port_ram twin_port_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/twin_port_ram_tb_top.sv
`timescale 1ns/100ps
module twin_port_ram_tb_top;
  localparam int AW = 10;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selNA, selA, wrEnA, selNB, selB, wrEnB;
  logic [AW-1:0] addrA, addrB;
  logic [DW-1:0] wdataA, wdataB;
  logic [DW-1:0] rdataA, rdataB;
  logic drvA, drvB, clash;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  // {addrA, dataA, addrB, dataB}: A and B write distinct words, then read crosswise.
  localparam logic [55:0] VEC [6] = '{
    {10'd3,   18'h01234, 10'd40,  18'h3abcd},
    {10'd0,   18'h3ffff, 10'd1023,18'h00001},
    {10'd512, 18'h2aaaa, 10'd511, 18'h15555},
    {10'd77,  18'h00000, 10'd78,  18'h3fffe},
    {10'd200, 18'h12345, 10'd201, 18'h23456},
    {10'd900, 18'h0f0f0, 10'd901, 18'h30303}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setA(input logic en, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    selNA = !en; selA = 1'b1; wrEnA = wr; addrA = a; wdataA = d;
  endtask

  task automatic setB(input logic en, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    selNB = !en; selB = 1'b1; wrEnB = wr; addrB = a; wdataB = d;
  endtask

  task automatic idle();
    setA(1'b1, 1'b0, '0, '0);
    setB(1'b1, 1'b0, '0, '0);
  endtask

  initial begin
    #(5.0 * 20000);
    nTests++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    idle();
    tick(); tick();
    // R10: reset state
    chk("R10 drvA", {31'd0, drvA}, 32'd0);
    chk("R10 drvB", {31'd0, drvB}, 32'd0);
    chk("R10 clash", {31'd0, clash}, 32'd0);
    chk("R10 rdataA", {14'd0, rdataA}, 32'd0);
    rstN = 1'b1;
    tick();

    // R2 / R1: table walk
    for (int i = 0; i < 6; i++) begin
      setA(1'b1, 1'b1, VEC[i][55:46], VEC[i][45:28]);
      setB(1'b1, 1'b1, VEC[i][27:18], VEC[i][17:0]);
      tick();
      setA(1'b1, 1'b0, VEC[i][27:18], '0);
      setB(1'b1, 1'b0, VEC[i][55:46], '0);
      tick();
      idle();
      tick();
      chk("R2 A reads B word", {14'd0, rdataA}, {14'd0, VEC[i][17:0]});
      chk("R2 B reads A word", {14'd0, rdataB}, {14'd0, VEC[i][45:28]});
      chk("R1 drvA", {31'd0, drvA}, 32'd1);
    end

    // R3: both read the same word
    setA(1'b1, 1'b0, 10'd3, '0);
    setB(1'b1, 1'b0, 10'd3, '0);
    tick(); idle(); tick();
    chk("R3 A", {14'd0, rdataA}, 32'h01234);
    chk("R3 B", {14'd0, rdataB}, 32'h01234);

    // R4: A writes word 40 while B reads it
    setA(1'b1, 1'b1, 10'd40, 18'h11111);
    setB(1'b1, 1'b0, 10'd40, '0);
    tick();
    setA(1'b1, 1'b0, '0, '0);
    tick();
    chk("R4 old data", {14'd0, rdataB}, 32'h3abcd);
    tick();
    chk("R4 new data", {14'd0, rdataB}, 32'h11111);

    // R5: same-word dual write
    setA(1'b1, 1'b1, 10'd50, 18'h0aaaa);
    setB(1'b1, 1'b1, 10'd50, 18'h05555);
    tick();
    idle();
    chk("R5 clash not early", {31'd0, clash}, 32'd0);
    setA(1'b1, 1'b0, 10'd50, '0);
    tick();
    chk("R5 clash", {31'd0, clash}, 32'd1);
    idle();
    tick();
    chk("R5 clash one cycle", {31'd0, clash}, 32'd0);
    chk("R5 A data kept", {14'd0, rdataA}, 32'h0aaaa);

    // R6 / R9: write, then change inputs right after the edge
    setA(1'b1, 1'b1, 10'd5, 18'h2468a);
    tick();
    setA(1'b1, 1'b0, 10'd5, 18'h13579);
    tick();
    chk("R9 no drive after write", {31'd0, drvA}, 32'd0);
    idle();
    tick();
    chk("R6 sampled data", {14'd0, rdataA}, 32'h2468a);

    // R7 / R8: active-low select deasserted with a write pending
    setA(1'b0, 1'b1, 10'd5, 18'h3ffff);
    tick();
    chk("R7 drvA off", {31'd0, drvA}, 32'd0);
    chk("R7 rdataA zero", {14'd0, rdataA}, 32'd0);
    setA(1'b1, 1'b0, 10'd5, '0);
    tick();
    chk("R8 not yet driving", {31'd0, drvA}, 32'd0);
    tick();
    chk("R8 driving", {31'd0, drvA}, 32'd1);
    chk("R7 write ignored", {14'd0, rdataA}, 32'h2468a);

    // R7 / R8: active-high select deasserted on port B
    setB(1'b1, 1'b1, 10'd6, 18'h00abc);
    tick();
    selB = 1'b0; wrEnB = 1'b1; addrB = 10'd6; wdataB = 18'h11111;
    tick();
    chk("R7 drvB off", {31'd0, drvB}, 32'd0);
    setB(1'b1, 1'b0, 10'd6, '0);
    tick();
    chk("R8 B not yet driving", {31'd0, drvB}, 32'd0);
    tick();
    chk("R8 B driving", {31'd0, drvB}, 32'd1);
    chk("R7 B write ignored", {14'd0, rdataB}, 32'h00abc);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule